// File: doc/BRIEF.md
# Sleep-Time Auto-NACK and Address Wake Unit

This unit sits beside an I2C target engine that stays powered while the rest of the system sleeps. Software arms the auto-NACK feature before sleeping; once armed, the unit drives a force-NACK request to the target engine. The engine then refuses every byte instead of stretching the clock, so the bus stays usable while nobody is awake to service it. The arm request is deferred: it only takes hold at the next byte boundary reported by the engine.

While the system is asleep and auto-NACK is active, each received address byte is compared with the target's own 7-bit address. On a match, the byte is still NACKed. Once the NACK bit slot of that byte completes, the unit issues a one-clock wake pulse and disarms itself. Software can also disarm it at any time with a clear command.

A registered status byte reports bus activity and the direction of the last normally handled host transaction. While auto-NACK is active, the status byte shows only the auto-NACK flag.

Top module: `sleep_nack_waker`

## Requirements
- R1: An arm command does not activate auto-NACK at once. Auto-NACK becomes active at the first `byte_bound` pulse sampled in a later cycle than the arm command. A boundary in the same cycle as the arm does not count.
- R2: `force_nack` is high exactly while auto-NACK is active. It changes one clock after the event that caused the change.
- R3: While `sleeping` is high and auto-NACK is active, an `addr_valid` byte whose bits [7:1] equal `own_addr` is remembered. On the next `nack_done` pulse, `wake_pulse` is high for exactly the following clock cycle.
- R4: No wake pulse results from an address whose bits [7:1] differ from `own_addr`, from an address received while `sleeping` is low, or from an address received while auto-NACK is inactive.
- R5: Auto-NACK is disarmed in the same clock edge that raises `wake_pulse`.
- R6: A `clear_cmd` disarms auto-NACK, cancels a pending arm, and forgets a remembered match. It has priority over `arm_cmd` in the same cycle.
- R7: Status encoding: bit 7 is bus busy, bit 6 means the last host transaction was a write, bit 5 means it was a read, bit 2 means auto-NACK is active, and all other bits are zero. Bit 0 of an address byte is the direction (1 = read, 0 = write).
- R8: While auto-NACK is active, the status byte reads exactly 0x04.
- R9: Bus busy sets on `start_evt` and clears on `stop_evt`; start wins if both occur together.
- R10: The read/write flags are updated only by address bytes received while auto-NACK is inactive. Addresses refused under auto-NACK leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 7 | Target's own 7-bit address |
| addr_byte | input | 8 | Received address byte, bit 0 = direction |
| addr_valid | input | 1 | Pulse: `addr_byte` is a freshly received address |
| byte_bound | input | 1 | Pulse: a byte boundary on the bus |
| nack_done | input | 1 | Pulse: the ACK/NACK bit slot of the current byte ended |
| start_evt | input | 1 | Pulse: start condition seen |
| stop_evt | input | 1 | Pulse: stop condition seen |
| sleeping | input | 1 | High while the host system sleeps |
| arm_cmd | input | 1 | Pulse: request auto-NACK |
| clear_cmd | input | 1 | Pulse: cancel auto-NACK |
| force_nack | output | 1 | Request to the engine to NACK every byte |
| wake_pulse | output | 1 | One-clock wake request |
| status | output | 8 | Transaction status byte |

## Verification
The bench feeds arm commands placed before a boundary, on the same cycle as a boundary, and together with a clear. This separates deferred activation from immediate activation and shows that clear takes priority.

Address frames are sent with a matching address, a mismatching address, and a match while awake. Only the sleeping match may wake and disarm the unit.

Read and write frames are sent with auto-NACK both off and on. This shows that the direction flags follow only frames handled normally, and that the status mask hides them while armed. A behavioural model is compared with every output on every clock.

// File: rtl/snw_pkg.sv
package snw_pkg;
  localparam int STAT_W      = 8;
  localparam int BIT_BUSY    = 7;
  localparam int BIT_LASTWR  = 6;
  localparam int BIT_LASTRD  = 5;
  localparam int BIT_ANACK   = 2;

  typedef struct packed {
    logic busy;
    logic last_wr;
    logic last_rd;
  } bus_flags_t;

  function automatic logic [STAT_W-1:0] pack_status(input bus_flags_t f, input logic anack);
    logic [STAT_W-1:0] s;
    s = '0;
    if (anack) begin
      s[BIT_ANACK] = 1'b1;
    end else begin
      s[BIT_BUSY]   = f.busy;
      s[BIT_LASTWR] = f.last_wr;
      s[BIT_LASTRD] = f.last_rd;
    end
    return s;
  endfunction
endpackage

// File: rtl/snw_arm_ctrl.sv
module snw_arm_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic arm_cmd,
  input  logic clear_cmd,
  input  logic byte_bound,
  input  logic wake_fire,
  output logic active_q,
  output logic active_d
);
  logic pend_q, pend_d;

  always_comb begin
    if (clear_cmd)              pend_d = 1'b0;
    else if (arm_cmd)           pend_d = 1'b1;
    else if (byte_bound)        pend_d = 1'b0;
    else                        pend_d = pend_q;

    if (clear_cmd || wake_fire)    active_d = 1'b0;
    else if (byte_bound && pend_q) active_d = 1'b1;
    else                           active_d = active_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      active_q <= active_d;
    end
  end
endmodule

// File: rtl/snw_addr_match.sv
module snw_addr_match #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W:0]   addr_byte,
  input  logic              addr_valid,
  input  logic              nack_done,
  input  logic              stop_evt,
  input  logic              clear_cmd,
  input  logic              sleeping,
  input  logic              active_q,
  output logic              wake_fire,
  output logic              wake_q
);
  logic hold_q, hold_d;
  logic hit;

  assign hit       = addr_valid && active_q && sleeping && (addr_byte[ADDR_W:1] == own_addr);
  assign wake_fire = hold_q && nack_done;

  always_comb begin
    if (clear_cmd || stop_evt || wake_fire) hold_d = 1'b0;
    else if (hit)                           hold_d = 1'b1;
    else                                    hold_d = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      wake_q <= wake_fire;
    end
  end
endmodule

// File: rtl/snw_stat_track.sv
module snw_stat_track
  import snw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              addr_valid,
  input  logic              addr_dir,
  input  logic              active_q,
  input  logic              active_d,
  output logic [STAT_W-1:0] status_q
);
  bus_flags_t fl_q, fl_d;

  always_comb begin
    fl_d = fl_q;
    if (start_evt)     fl_d.busy = 1'b1;
    else if (stop_evt) fl_d.busy = 1'b0;
    if (addr_valid && !active_q) begin
      fl_d.last_rd = addr_dir;
      fl_d.last_wr = ~addr_dir;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_q     <= '0;
      status_q <= '0;
    end else begin
      fl_q     <= fl_d;
      status_q <= pack_status(fl_d, active_d);
    end
  end
endmodule

// File: rtl/sleep_nack_waker.sv
module sleep_nack_waker
  import snw_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W:0]   addr_byte,
  input  logic              addr_valid,
  input  logic              byte_bound,
  input  logic              nack_done,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sleeping,
  input  logic              arm_cmd,
  input  logic              clear_cmd,
  output logic              force_nack,
  output logic              wake_pulse,
  output logic [STAT_W-1:0] status
);
  logic active_q, active_d, wake_fire;

  snw_arm_ctrl u_arm (
    .clk(clk), .rst(rst), .arm_cmd(arm_cmd), .clear_cmd(clear_cmd),
    .byte_bound(byte_bound), .wake_fire(wake_fire),
    .active_q(active_q), .active_d(active_d)
  );

  snw_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst(rst), .own_addr(own_addr), .addr_byte(addr_byte),
    .addr_valid(addr_valid), .nack_done(nack_done), .stop_evt(stop_evt),
    .clear_cmd(clear_cmd), .sleeping(sleeping), .active_q(active_q),
    .wake_fire(wake_fire), .wake_q(wake_pulse)
  );

  snw_stat_track u_stat (
    .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
    .addr_valid(addr_valid), .addr_dir(addr_byte[0]),
    .active_q(active_q), .active_d(active_d), .status_q(status)
  );

  assign force_nack = active_q;
endmodule

// File: rtl/snw_checker.sv
module snw_checker (
  input logic       clk,
  input logic       rst,
  input logic       byte_bound,
  input logic       nack_done,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       sleeping,
  input logic       force_nack,
  input logic       wake_pulse,
  input logic [7:0] status
);
  AST_ARM_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(force_nack) |-> $past(byte_bound)); // R1
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse); // R3
  AST_WAKE_AFTER_NACK: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> $past(nack_done)); // R3
  AST_WAKE_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> $past(sleeping)); // R4
  AST_WAKE_DISARMS: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> !force_nack); // R5
  AST_STATUS_MASK: assert property (@(posedge clk) disable iff (rst)
    force_nack |-> status == 8'h04); // R8
  AST_STATUS_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (status & 8'h1B) == 8'h00); // R7
  AST_BUSY_STOP: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && !start_evt) |=> !status[7]); // R9
endmodule

bind sleep_nack_waker snw_checker chk_i (
  .clk(clk), .rst(rst), .byte_bound(byte_bound), .nack_done(nack_done),
  .start_evt(start_evt), .stop_evt(stop_evt), .sleeping(sleeping),
  .force_nack(force_nack), .wake_pulse(wake_pulse), .status(status)
);

// File: tb/sleep_nack_waker_tb.sv
module sleep_nack_waker_tb_top;
  logic       clk = 0;
  logic       rst = 1;
  logic [6:0] own_addr = 7'h15;
  logic [7:0] addr_byte = 0;
  logic addr_valid = 0, byte_bound = 0, nack_done = 0, start_evt = 0, stop_evt = 0;
  logic sleeping = 0, arm_cmd = 0, clear_cmd = 0;
  logic force_nack, wake_pulse;
  logic [7:0] status;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sleep_nack_waker dut_i (
    .clk(clk), .rst(rst), .own_addr(own_addr), .addr_byte(addr_byte),
    .addr_valid(addr_valid), .byte_bound(byte_bound), .nack_done(nack_done),
    .start_evt(start_evt), .stop_evt(stop_evt), .sleeping(sleeping),
    .arm_cmd(arm_cmd), .clear_cmd(clear_cmd),
    .force_nack(force_nack), .wake_pulse(wake_pulse), .status(status)
  );

  // behavioural reference
  bit m_pend, m_act, m_hold, m_busy, m_lw, m_lr, m_wake;
  always @(posedge clk) begin
    bit fire, n_act;
    if (rst) begin
      m_pend = 0; m_act = 0; m_hold = 0; m_busy = 0; m_lw = 0; m_lr = 0; m_wake = 0;
    end else begin
      fire = m_hold && nack_done;
      n_act = m_act;
      if (clear_cmd || fire) n_act = 0;
      else if (byte_bound && m_pend) n_act = 1;
      if (addr_valid && !m_act) begin m_lr = addr_byte[0]; m_lw = !addr_byte[0]; end
      if (start_evt) m_busy = 1; else if (stop_evt) m_busy = 0;
      if (clear_cmd || stop_evt || fire) m_hold = 0;
      else if (addr_valid && m_act && sleeping && addr_byte[7:1] == own_addr) m_hold = 1;
      if (clear_cmd) m_pend = 0; else if (arm_cmd) m_pend = 1; else if (byte_bound) m_pend = 0;
      m_wake = fire;
      m_act = n_act;
    end
  end

  function automatic [7:0] exp_status();
    if (m_act) return 8'h04;
    return {m_busy, m_lw, m_lr, 5'b0};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 force_nack", force_nack, m_act);
      chk("R3 wake_pulse", wake_pulse, m_wake);
      chk("R7 status", status, exp_status());
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_all();
    addr_valid = 0; byte_bound = 0; nack_done = 0; start_evt = 0;
    stop_evt = 0; arm_cmd = 0; clear_cmd = 0;
  endtask

  task automatic do_start(); start_evt = 1; tick(1); clr_all(); endtask
  task automatic do_stop();  stop_evt = 1;  tick(1); clr_all(); endtask
  task automatic do_arm();   arm_cmd = 1;   tick(1); clr_all(); endtask
  task automatic do_clear(); clear_cmd = 1; tick(1); clr_all(); endtask
  task automatic do_bound(); byte_bound = 1; tick(1); clr_all(); endtask
  task automatic do_addr(input logic [7:0] b);
    addr_byte = b; addr_valid = 1; byte_bound = 1; tick(1); clr_all();
  endtask
  task automatic do_nackdone(); nack_done = 1; tick(1); clr_all(); endtask

  // full frame: start, address, ack slot, stop
  task automatic frame(input logic [7:0] b);
    do_start(); tick(1); do_addr(b); do_nackdone(); tick(2); do_stop(); tick(1);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    chk("R7 reset status", status, 8'h00);
    chk("R2 reset force_nack", force_nack, 0);

    // normal write then read frames
    frame(8'h2A);
    chk("R10 last write", status, 8'h40);
    frame(8'h2B);
    chk("R10 last read", status, 8'h20);
    do_start();
    chk("R9 busy set", status[7], 1);
    do_stop();
    chk("R9 busy clear", status[7], 0);

    // arm deferred until boundary
    do_arm(); tick(3);
    chk("R1 not active before boundary", force_nack, 0);
    do_bound();
    chk("R1 active after boundary", force_nack, 1);
    chk("R8 status masked", status, 8'h04);

    // awake match: no wake
    frame(8'h2A);
    chk("R4 no wake while awake", force_nack, 1);
    sleeping = 1;
    // mismatch while asleep
    frame(8'h60);
    chk("R4 mismatch keeps armed", force_nack, 1);
    do_clear();
    chk("R6 clear disarms", force_nack, 0);
    chk("R10 refused frames leave read flag", status, 8'h20);

    // arm on same cycle as a boundary: waits for next one
    arm_cmd = 1; byte_bound = 1; tick(1); clr_all();
    chk("R1 same-cycle boundary ignored", force_nack, 0);
    do_bound();
    chk("R1 next boundary activates", force_nack, 1);

    // sleeping match wakes
    do_start(); do_addr(8'h2A);
    chk("R3 no wake before nack slot", wake_pulse, 0);
    do_nackdone();
    chk("R3 wake pulse", wake_pulse, 1);
    chk("R5 auto disarm", force_nack, 0);
    tick(1);
    chk("R3 wake single cycle", wake_pulse, 0);
    do_stop();
    sleeping = 0;

    // clear beats arm, cancels pending
    arm_cmd = 1; clear_cmd = 1; tick(1); clr_all();
    do_bound();
    chk("R6 clear priority", force_nack, 0);
    do_arm(); do_clear(); do_bound();
    chk("R6 pending cancelled", force_nack, 0);

    // match remembered then cleared before nack slot
    do_arm(); do_bound(); sleeping = 1;
    do_start(); do_addr(8'h2B); do_clear(); do_nackdone();
    chk("R6 match forgotten", wake_pulse, 0);
    do_stop(); sleeping = 0;
    chk("R7 final status", status, 8'h20);

    tick(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule